// File: doc/BRIEF.md
# Masked CAN Identifier Acceptance Filter

This block decides which receive slot an incoming CAN frame belongs to. It holds a bank of programmable filter objects. Each object has an enable bit, a direction bit, a 30-bit identifier pattern and a 29-bit don't-care mask. When a decoded frame identifier arrives with a valid strobe, every object compares it at the same time. The block reports whether any receive object accepted the frame and, if so, which one.

Standard and extended frames are compared in one unified 30-bit key: `{ide, base[10:0], ext[17:0]}`. For standard frames the extension part is forced to zero. The identifier-format bit is never maskable, so a standard object cannot claim an extended frame, and an extended object cannot claim a standard frame.

A simple write port loads one object's settings per clock. When several objects accept a frame, the lowest-numbered one wins. The verdict is registered and appears one clock after the strobe.

Top module: `can_id_accept_filter`

## Requirements
- R1: After reset, `hit_o` is 0, `obj_idx_o` is 0, and every object is disabled, so no frame is accepted until an object is written.
- R2: `hit_o` is high for exactly the cycle after a cycle with `frm_valid_i` high in which at least one object accepts the frame. In all other cycles it is low.
- R3: Key bit positions are: bit 29 is IDE, bits 28..18 are base ID bits 10..0, and bits 17..0 are extension bits 17..0. A mask bit i (0..28) set to 1 makes key bit i a don't-care. A mask bit i set to 0 requires key bit i to equal pattern bit i.
- R4: Pattern bit 29 (IDE) must always equal the frame's IDE bit, whatever the mask holds.
- R5: For a frame with IDE=0, the extension input is ignored and key bits 17..0 are treated as zero.
- R6: An object whose enable bit is 0 never accepts a frame.
- R7: An object whose direction bit marks it as transmit (`cfg_rx_i`=0 when written) never accepts a frame.
- R8: When several objects accept one frame, `obj_idx_o` reports the lowest index among them.
- R9: When a strobed frame is accepted by no object, `hit_o` stays low and `obj_idx_o` keeps its previous value. `obj_idx_o` changes only together with a hit.
- R10: A configuration write takes effect at the clock edge on which it is sampled. A frame strobed in that same cycle is judged with the settings held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for one object's settings |
| cfg_idx_i | input | 5 | Object number being written |
| cfg_en_i | input | 1 | Enable bit for the written object |
| cfg_rx_i | input | 1 | 1 = receive object, 0 = transmit object |
| cfg_match_i | input | 30 | Identifier pattern in key layout |
| cfg_mask_i | input | 29 | Don't-care mask over key bits 28..0 |
| frm_valid_i | input | 1 | Frame identifier strobe |
| frm_ide_i | input | 1 | 0 = standard frame, 1 = extended frame |
| frm_base_i | input | 11 | Base identifier |
| frm_ext_i | input | 18 | Extended identifier bits |
| hit_o | output | 1 | Frame accepted by some receive object (one cycle after strobe) |
| obj_idx_o | output | 5 | Index of the winning object |

## Verification
The assertions check the following on every cycle:
- the hit flag agrees with the strobe and with the per-object candidate vector;
- a reported index is a candidate with no lower-numbered candidate;
- the index holds between hits;
- no disabled or transmit object raises a candidate;
- no candidate has a different IDE bit from the frame.

Only the bench scenarios can show whether the candidate vector itself is right. These scenarios cover:
- the exact field positions of the mask;
- the zeroing of extension bits for standard frames;
- the old-versus-new settings when a write and a frame share a cycle;
- back-to-back frames whose verdicts must come out in order.

// File: rtl/can_idf_pkg.sv
package can_idf_pkg;

    localparam int BASE_W = 11;
    localparam int EXT_W  = 18;
    localparam int ID_W   = BASE_W + EXT_W;
    localparam int KEY_W  = ID_W + 1;

    typedef struct packed {
        logic             en;
        logic             rx;
        logic [KEY_W-1:0] pattern;
        logic [ID_W-1:0]  dont_care;
    } obj_cfg_t;

endpackage

// File: rtl/idf_cfg_bank.sv
module idf_cfg_bank
    import can_idf_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int IDX_W   = 5
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   wr_en_i,
    input  logic [IDX_W-1:0]       wr_idx_i,
    input  obj_cfg_t               wr_cfg_i,
    output obj_cfg_t [NUM_OBJ-1:0] cfg_o
);

    obj_cfg_t [NUM_OBJ-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i && (32'(wr_idx_i) < NUM_OBJ)) begin
            bank_d[wr_idx_i] = wr_cfg_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cfg_o = bank_q;

endmodule

// File: rtl/idf_match_array.sv
module idf_match_array
    import can_idf_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  obj_cfg_t [NUM_OBJ-1:0] cfg_i,
    input  logic                   ide_i,
    input  logic [BASE_W-1:0]      base_i,
    input  logic [EXT_W-1:0]       ext_i,
    output logic [NUM_OBJ-1:0]     cand_o
);

    logic [KEY_W-1:0] key;

    always_comb begin
        key = {ide_i, base_i, (ide_i ? ext_i : {EXT_W{1'b0}})};
    end

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        logic fmt_ok;
        logic id_ok;
        always_comb begin
            fmt_ok    = (key[KEY_W-1] == cfg_i[g].pattern[KEY_W-1]);
            id_ok     = ~|((key[ID_W-1:0] ^ cfg_i[g].pattern[ID_W-1:0])
                           & ~cfg_i[g].dont_care);
            cand_o[g] = cfg_i[g].en & cfg_i[g].rx & fmt_ok & id_ok;
        end
    end

endmodule

// File: rtl/idf_first_hit.sv
module idf_first_hit #(
    parameter int NUM_OBJ = 32,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_OBJ-1:0] cand_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        any_o = |cand_i;
        idx_o = '0;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/can_id_accept_filter.sv
module can_id_accept_filter
    import can_idf_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic              cfg_en_i,
    input  logic              cfg_rx_i,
    input  logic [KEY_W-1:0]  cfg_match_i,
    input  logic [ID_W-1:0]   cfg_mask_i,
    input  logic              frm_valid_i,
    input  logic              frm_ide_i,
    input  logic [BASE_W-1:0] frm_base_i,
    input  logic [EXT_W-1:0]  frm_ext_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  obj_idx_o
);

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } verdict_t;

    obj_cfg_t               wr_cfg;
    obj_cfg_t [NUM_OBJ-1:0] cfg_arr;
    logic [NUM_OBJ-1:0]     cand_vec;
    logic                   any_cand;
    logic [IDX_W-1:0]       first_idx;
    verdict_t               res_d, res_q;

    always_comb begin
        wr_cfg.en        = cfg_en_i;
        wr_cfg.rx        = cfg_rx_i;
        wr_cfg.pattern   = cfg_match_i;
        wr_cfg.dont_care = cfg_mask_i;
    end

    idf_cfg_bank #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (cfg_we_i),
        .wr_idx_i (cfg_idx_i),
        .wr_cfg_i (wr_cfg),
        .cfg_o    (cfg_arr)
    );

    idf_match_array #(.NUM_OBJ(NUM_OBJ)) u_match (
        .cfg_i  (cfg_arr),
        .ide_i  (frm_ide_i),
        .base_i (frm_base_i),
        .ext_i  (frm_ext_i),
        .cand_o (cand_vec)
    );

    idf_first_hit #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_pick (
        .cand_i (cand_vec),
        .any_o  (any_cand),
        .idx_o  (first_idx)
    );

    always_comb begin
        res_d     = res_q;
        res_d.hit = frm_valid_i & any_cand;
        if (frm_valid_i && any_cand) begin
            res_d.idx = first_idx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit_o     = res_q.hit;
    assign obj_idx_o = res_q.idx;

endmodule

// File: rtl/can_id_accept_filter_chk.sv
module can_id_accept_filter_chk
    import can_idf_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int IDX_W   = 5
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   frm_valid_i,
    input logic                   frm_ide_i,
    input logic                   hit_o,
    input logic [IDX_W-1:0]       obj_idx_o,
    input logic [NUM_OBJ-1:0]     cand_vec,
    input obj_cfg_t [NUM_OBJ-1:0] cfg_arr
);

    logic [NUM_OBJ-1:0] prev_cand;
    logic               win_is_cand;
    logic               lower_clear;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_cand <= '0;
        end else begin
            prev_cand <= cand_vec;
        end
    end

    always_comb begin
        win_is_cand = 1'b0;
        lower_clear = 1'b1;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (32'(obj_idx_o) == i) begin
                win_is_cand = prev_cand[i];
            end
            if (i < 32'(obj_idx_o) && prev_cand[i]) begin
                lower_clear = 1'b0;
            end
        end
    end

    // R2: no strobe, no hit next cycle
    p_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frm_valid_i |=> !hit_o);

    // R2: a strobe produces a hit exactly when some candidate existed
    p_hit_tracks_cand_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frm_valid_i |=> (hit_o == $past(|cand_vec)));

    // R8: the reported index is the lowest candidate
    p_lowest_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (win_is_cand && lower_clear));

    // R9: the index moves only together with a hit
    p_idx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_o |-> $stable(obj_idx_o));

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        // R6, R7: only enabled receive objects can raise a candidate
        p_rx_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cand_vec[g] |-> (cfg_arr[g].en && cfg_arr[g].rx));

        // R4: the format bit is compared exactly
        p_ide_exact_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cand_vec[g] |-> (cfg_arr[g].pattern[KEY_W-1] == frm_ide_i));
    end

endmodule

bind can_id_accept_filter can_id_accept_filter_chk #(
    .NUM_OBJ (NUM_OBJ),
    .IDX_W   (IDX_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frm_valid_i (frm_valid_i),
    .frm_ide_i   (frm_ide_i),
    .hit_o       (hit_o),
    .obj_idx_o   (obj_idx_o),
    .cand_vec    (cand_vec),
    .cfg_arr     (cfg_arr)
);

// File: tb/can_id_accept_filter_bench.sv
`timescale 1ns/1ps
module can_id_accept_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic        cfg_rx = 1'b0;
    logic [29:0] cfg_match = '0;
    logic [28:0] cfg_mask = '0;
    logic        frm_valid = 1'b0;
    logic        frm_ide = 1'b0;
    logic [10:0] frm_base = '0;
    logic [17:0] frm_ext = '0;
    logic        hit;
    logic [4:0]  obj_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    can_id_accept_filter u_can_id_accept_filter (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_idx_i   (cfg_idx),
        .cfg_en_i    (cfg_en),
        .cfg_rx_i    (cfg_rx),
        .cfg_match_i (cfg_match),
        .cfg_mask_i  (cfg_mask),
        .frm_valid_i (frm_valid),
        .frm_ide_i   (frm_ide),
        .frm_base_i  (frm_base),
        .frm_ext_i   (frm_ext),
        .hit_o       (hit),
        .obj_idx_o   (obj_idx)
    );

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_verdict(string req, bit exp_hit, int exp_idx);
        check({req, " hit"}, int'(hit), int'(exp_hit));
        check({req, " idx"}, int'(obj_idx), exp_idx);
    endtask

    task automatic put_obj(int idx, bit en, bit rx, bit ide,
                           logic [10:0] b, logic [17:0] e, logic [28:0] m);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 5'(idx);
        cfg_en    = en;
        cfg_rx    = rx;
        cfg_match = {ide, b, e};
        cfg_mask  = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(bit ide, logic [10:0] b, logic [17:0] e);
        @(negedge clk);
        frm_valid = 1'b1;
        frm_ide   = ide;
        frm_base  = b;
        frm_ext   = e;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic t_reset();
        check_verdict("R1 after reset", 1'b0, 0);
        probe(1'b0, 11'h000, 18'h0);
        check_verdict("R1 all objects disabled", 1'b0, 0);
    endtask

    task automatic t_exact();
        put_obj(5, 1, 1, 0, 11'h123, 18'h0, 29'h0);
        probe(1'b0, 11'h123, 18'h3FFFF);
        check_verdict("R3 R5 exact standard hit", 1'b1, 5);
        probe(1'b0, 11'h124, 18'h0);
        check_verdict("R9 miss keeps index", 1'b0, 5);
        probe(1'b1, 11'h123, 18'h0);
        check_verdict("R4 extended frame vs standard object", 1'b0, 5);
        put_obj(6, 1, 1, 0, 11'h055, 18'h00001, 29'h0);
        probe(1'b0, 11'h055, 18'h00001);
        check_verdict("R5 standard key has zero extension", 1'b0, 5);
    endtask

    task automatic t_mask();
        put_obj(7, 1, 1, 1, 11'h1AB, 18'h20000, 29'h00000FF);
        probe(1'b1, 11'h1AB, 18'h20055);
        check_verdict("R3 low mask bits ignored", 1'b1, 7);
        probe(1'b1, 11'h1AB, 18'h20155);
        check_verdict("R3 unmasked bit 8 compared", 1'b0, 7);
        put_obj(8, 1, 1, 1, 11'h400, 18'h00001, 29'h1000_0000);
        probe(1'b1, 11'h000, 18'h00001);
        check_verdict("R3 mask bit 28 covers base bit 10", 1'b1, 8);
    endtask

    task automatic t_ide();
        put_obj(9, 1, 1, 0, 11'h0, 18'h0, 29'h1FFF_FFFF);
        probe(1'b0, 11'h7FF, 18'h12345);
        check_verdict("R4 wildcard standard object", 1'b1, 9);
        probe(1'b1, 11'h7FF, 18'h0);
        check_verdict("R4 IDE not maskable", 1'b0, 9);
        probe(1'b0, 11'h123, 18'h0);
        check_verdict("R8 object 5 below wildcard 9", 1'b1, 5);
    endtask

    task automatic t_prio();
        put_obj(2, 1, 1, 0, 11'h0, 18'h0, 29'h1FFF_FFFF);
        probe(1'b0, 11'h7FF, 18'h0);
        check_verdict("R8 lower wildcard wins", 1'b1, 2);
        put_obj(2, 0, 1, 0, 11'h0, 18'h0, 29'h1FFF_FFFF);
        probe(1'b0, 11'h7FF, 18'h0);
        check_verdict("R6 disabled object skipped", 1'b1, 9);
        put_obj(2, 1, 0, 0, 11'h0, 18'h0, 29'h1FFF_FFFF);
        probe(1'b0, 11'h7FF, 18'h0);
        check_verdict("R7 transmit object skipped", 1'b1, 9);
        put_obj(31, 1, 1, 1, 11'h0, 18'h0, 29'h1FFF_FFFF);
        probe(1'b1, 11'h7FF, 18'h3FFFF);
        check_verdict("R8 top object alone", 1'b1, 31);
        probe(1'b1, 11'h1AB, 18'h20055);
        check_verdict("R8 object 7 beats 31", 1'b1, 7);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 5'd9;
        cfg_en    = 1'b0;
        cfg_rx    = 1'b1;
        cfg_match = '0;
        cfg_mask  = 29'h1FFF_FFFF;
        frm_valid = 1'b1;
        frm_ide   = 1'b0;
        frm_base  = 11'h7FF;
        frm_ext   = 18'h0;
        @(negedge clk);
        cfg_we    = 1'b0;
        frm_valid = 1'b0;
        check_verdict("R10 frame sees old settings", 1'b1, 9);
        probe(1'b0, 11'h7FF, 18'h0);
        check_verdict("R10 next frame sees new settings", 1'b0, 9);
    endtask

    task automatic t_stream();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R2 idle cycle hit", int'(hit), 0);
        end
        @(negedge clk);
        frm_valid = 1'b1;
        frm_ide   = 1'b1;
        frm_base  = 11'h1AB;
        frm_ext   = 18'h20000;
        @(negedge clk);
        frm_ide   = 1'b0;
        frm_base  = 11'h123;
        frm_ext   = 18'h0;
        check_verdict("R2 first of back-to-back", 1'b1, 7);
        @(negedge clk);
        frm_valid = 1'b0;
        check_verdict("R2 second of back-to-back", 1'b1, 5);
        @(negedge clk);
        check("R2 pulse ends", int'(hit), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_mask();
        t_ide();
        t_prio();
        t_same_cycle();
        t_stream();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule